// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block works out the next program counter for a small 8-bit processor with a 16-bit code address space. For every instruction it receives the opcode, the already-incremented PC (the address just past the instruction's last byte) and the operands and machine state that any control-transfer instruction might need. It then chooses one of several targets: the sequential address, an in-page target, a full 16-bit address, a return address from the stack, a signed relative target, the data pointer, or the data pointer plus the accumulator.

Conditional branches test one of four condition flags, either true or complemented. Two of them are decided inside the unit: decrement-and-branch and compare-and-branch. A call indicator tells the stack logic to save the incremented PC. The result is registered, so the selected address and the call indicator show up one clock after the inputs are presented. Stack storage, register write-back and fetch belong to neighbouring blocks.

Top module: `pcu_next_pc`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `next_pc` becomes 0x0000 and `push_ret` becomes 0.
- R2: For opcodes 0xC0–0xCF the target is `{pc_inc[15:11], opcode[2:0], imm8}`.
- R3: `push_ret` is 1 for opcodes 0xC8–0xCF and 0xD9, and 0 for every other opcode.
- R4: Opcodes 0xD8 and 0xD9 select `addr16` as the target.
- R5: Opcodes 0xDA and 0xDB select `stack_ret` as the target.
- R6: A relative target is `pc_inc` plus `imm8` read as a signed two's-complement byte, modulo 2^16. Opcode 0xDC always takes it.
- R7: Opcode 0xDD selects `dptr + acc`, with `acc` unsigned and the sum taken modulo 2^16. Opcode 0xDE selects `dptr`.
- R8: Opcodes 0xE0–0xE7 take the relative target when, in order, `flag_z`, !`flag_z`, `flag_c`, !`flag_c`, `flag_p`, !`flag_p`, `flag_s`, !`flag_s` is 1 (`flag_p`=1 means odd parity, `flag_s`=1 means negative).
- R9: Opcodes 0xD0–0xD3 take the relative target when `reg_val - 1` (mod 256) is nonzero. So `reg_val`=0x01 falls through and `reg_val`=0x00 branches.
- R10: Opcodes 0xD4–0xD7 take the relative target when `reg_val` differs from `cmp8`. Opcode 0xDF does the same, comparing `acc` with `cmp8`.
- R11: Any branch that is not taken, and every opcode below 0xC0 or from 0xE8 up, yields `pc_inc`.
- R12: Both outputs are registered. Values driven before a rising edge appear on the outputs just after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 8 | Current instruction opcode |
| pc_inc | input | 16 | Address following the current instruction |
| imm8 | input | 8 | In-page address byte or signed displacement |
| cmp8 | input | 8 | Immediate compare byte for compare-and-branch |
| addr16 | input | 16 | Absolute target operand |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| stack_ret | input | 16 | Return address popped from the stack |
| reg_val | input | 8 | Register selected by the opcode for decrement or compare |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_p | input | 1 | Parity flag, 1 = odd |
| flag_s | input | 1 | Sign flag, 1 = negative |
| next_pc | output | 16 | Selected next program counter (registered) |
| push_ret | output | 1 | Call indicator: save `pc_inc` as return address (registered) |

## Verification
The assertions assume that every input is a known value on each rising edge after reset. They do not assume that operands are consistent with the opcode: the unit must ignore the operands an opcode does not use. The stimulus therefore drives all operand and flag inputs with fresh random values every cycle. Opcodes are biased towards 0xC0–0xFF, and `reg_val` and `cmp8` are steered often onto the boundary values where decrement-and-branch and compare-and-branch change their decision.

// File: rtl/pcu_pkg.sv
// Package pcu_pkg
// Shared encodings for the next-address unit: where the target comes
// from, and which kind of branch decision gates it.
// Assumes the 8-bit opcode space of the host processor.
package pcu_pkg;

    localparam int OPC_W = 8;

    // Source of the candidate target address.
    typedef enum logic [2:0] {
        SRC_SEQ   = 3'd0,
        SRC_PAGE  = 3'd1,
        SRC_ABS   = 3'd2,
        SRC_STACK = 3'd3,
        SRC_REL   = 3'd4,
        SRC_IDX   = 3'd5,
        SRC_DPTR  = 3'd6
    } tgt_src_e;

    // Decision that gates the candidate target.
    typedef enum logic [2:0] {
        CND_ALWAYS = 3'd0,
        CND_FLAG   = 3'd1,
        CND_DECNZ  = 3'd2,
        CND_NE_REG = 3'd3,
        CND_NE_ACC = 3'd4
    } cond_kind_e;

    typedef struct packed {
        tgt_src_e   src;
        cond_kind_e cond;
        logic       push;
    } decode_t;

endpackage

// File: rtl/pcu_decode.sv
// Module pcu_decode
// Maps an opcode onto a target source, a branch-decision kind and the
// call indicator. Purely combinational. Opcodes outside the control
// transfer range decode to the sequential address with no push.
module pcu_decode
    import pcu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output decode_t          dec
);

    // Classify the opcode by its upper bits, then by its low bits.
    always_comb begin
        dec = '{src: SRC_SEQ, cond: CND_ALWAYS, push: 1'b0};
        unique case (opcode[7:4])
            4'hC: begin
                dec.src  = SRC_PAGE;
                dec.push = opcode[3];
            end
            4'hD: begin
                case (opcode[3:0])
                    4'h0, 4'h1, 4'h2, 4'h3: begin
                        dec.src  = SRC_REL;
                        dec.cond = CND_DECNZ;
                    end
                    4'h4, 4'h5, 4'h6, 4'h7: begin
                        dec.src  = SRC_REL;
                        dec.cond = CND_NE_REG;
                    end
                    4'h8: dec.src = SRC_ABS;
                    4'h9: begin
                        dec.src  = SRC_ABS;
                        dec.push = 1'b1;
                    end
                    4'hA, 4'hB: dec.src = SRC_STACK;
                    4'hC: dec.src = SRC_REL;
                    4'hD: dec.src = SRC_IDX;
                    4'hE: dec.src = SRC_DPTR;
                    default: begin
                        dec.src  = SRC_REL;
                        dec.cond = CND_NE_ACC;
                    end
                endcase
            end
            4'hE: begin
                if (!opcode[3]) begin
                    dec.src  = SRC_REL;
                    dec.cond = CND_FLAG;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pcu_cond.sv
// Module pcu_cond
// Decides whether a gated branch is taken. Flag branches pick one of
// four flags, true or complemented, with the low three opcode bits.
// Counter and compare branches are resolved from the operand bytes.
// Assumes flag_p = 1 means odd parity and flag_s = 1 means negative.
module pcu_cond
    import pcu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  cond_kind_e        kind,
    input  logic [2:0]        sel,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic              flag_p,
    input  logic              flag_s,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] cmp8,
    output logic              taken
);

    localparam int NFLAG = 4;

    logic [NFLAG-1:0]   base_flags;
    logic [2*NFLAG-1:0] flag_tests;
    logic [DATA_W-1:0]  dec_val;

    assign base_flags = {flag_s, flag_p, flag_c, flag_z};

    // Each flag yields a pair of tests: set, then clear.
    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag_pair
        assign flag_tests[2*gi]   = base_flags[gi];
        assign flag_tests[2*gi+1] = ~base_flags[gi];
    end

    assign dec_val = reg_val - DATA_W'(1);

    // Select the decision for the decoded branch kind.
    always_comb begin
        case (kind)
            CND_FLAG:   taken = flag_tests[sel];
            CND_DECNZ:  taken = |dec_val;
            CND_NE_REG: taken = (reg_val != cmp8);
            CND_NE_ACC: taken = (acc != cmp8);
            default:    taken = 1'b1;
        endcase
    end

endmodule

// File: rtl/pcu_target.sv
// Module pcu_target
// Builds every candidate target and selects one. A gated branch that
// is not taken falls back to the sequential address. All arithmetic
// wraps modulo 2^PC_W. Assumes PC_W > DATA_W + 3.
module pcu_target
    import pcu_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DATA_W = 8
) (
    input  tgt_src_e          src,
    input  logic              taken,
    input  logic [2:0]        page_sel,
    input  logic [PC_W-1:0]   pc_inc,
    input  logic [DATA_W-1:0] imm8,
    input  logic [PC_W-1:0]   addr16,
    input  logic [DATA_W-1:0] acc,
    input  logic [PC_W-1:0]   dptr,
    input  logic [PC_W-1:0]   stack_ret,
    output logic [PC_W-1:0]   target
);

    localparam int PAGE_LO = DATA_W + 3;
    localparam int EXT_W   = PC_W - DATA_W;

    logic [PC_W-1:0] page_tgt;
    logic [PC_W-1:0] rel_tgt;
    logic [PC_W-1:0] idx_tgt;

    assign page_tgt = {pc_inc[PC_W-1:PAGE_LO], page_sel, imm8};
    assign rel_tgt  = pc_inc + {{EXT_W{imm8[DATA_W-1]}}, imm8};
    assign idx_tgt  = dptr + {{EXT_W{1'b0}}, acc};

    // Pick the candidate; untaken branches continue in sequence.
    always_comb begin
        if (!taken) begin
            target = pc_inc;
        end else begin
            case (src)
                SRC_PAGE:  target = page_tgt;
                SRC_ABS:   target = addr16;
                SRC_STACK: target = stack_ret;
                SRC_REL:   target = rel_tgt;
                SRC_IDX:   target = idx_tgt;
                SRC_DPTR:  target = dptr;
                default:   target = pc_inc;
            endcase
        end
    end

endmodule

// File: rtl/pcu_next_pc.sv
// Module pcu_next_pc
// Top of the next-address unit. Decodes the opcode, resolves the
// branch decision, selects the target and registers it together with
// the call indicator. One cycle from inputs to outputs.
// Assumes all inputs are stable and known around each rising edge.
module pcu_next_pc
    import pcu_pkg::*;
#(
    parameter int              PC_W     = 16,
    parameter int              DATA_W   = 8,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        opcode,
    input  logic [PC_W-1:0]   pc_inc,
    input  logic [DATA_W-1:0] imm8,
    input  logic [DATA_W-1:0] cmp8,
    input  logic [PC_W-1:0]   addr16,
    input  logic [DATA_W-1:0] acc,
    input  logic [PC_W-1:0]   dptr,
    input  logic [PC_W-1:0]   stack_ret,
    input  logic [DATA_W-1:0] reg_val,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic              flag_p,
    input  logic              flag_s,
    output logic [PC_W-1:0]   next_pc,
    output logic              push_ret
);

    decode_t         dec;
    logic            taken;
    logic [PC_W-1:0] target;

    pcu_decode u_decode (
        .opcode (opcode),
        .dec    (dec)
    );

    pcu_cond #(.DATA_W(DATA_W)) u_cond (
        .kind    (dec.cond),
        .sel     (opcode[2:0]),
        .flag_z  (flag_z),
        .flag_c  (flag_c),
        .flag_p  (flag_p),
        .flag_s  (flag_s),
        .reg_val (reg_val),
        .acc     (acc),
        .cmp8    (cmp8),
        .taken   (taken)
    );

    pcu_target #(.PC_W(PC_W), .DATA_W(DATA_W)) u_target (
        .src       (dec.src),
        .taken     (taken),
        .page_sel  (opcode[2:0]),
        .pc_inc    (pc_inc),
        .imm8      (imm8),
        .addr16    (addr16),
        .acc       (acc),
        .dptr      (dptr),
        .stack_ret (stack_ret),
        .target    (target)
    );

    // Register the chosen address and the call indicator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc  <= RESET_PC;
            push_ret <= 1'b0;
        end else begin
            next_pc  <= target;
            push_ret <= dec.push;
        end
    end

endmodule

// File: rtl/pcu_next_pc_chk.sv
// Module pcu_next_pc_chk
// Port-level checks on the registered outputs against the inputs
// sampled one edge earlier. Attached to the top with a bind.
module pcu_next_pc_chk #(
    parameter int PC_W   = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        opcode,
    input logic [PC_W-1:0]   pc_inc,
    input logic [DATA_W-1:0] imm8,
    input logic [PC_W-1:0]   addr16,
    input logic [PC_W-1:0]   dptr,
    input logic [PC_W-1:0]   stack_ret,
    input logic [PC_W-1:0]   next_pc,
    input logic              push_ret
);

    localparam int PAGE_LO = DATA_W + 3;

    // Page targets keep the upper PC bits and splice opcode and byte.
    assert_page_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode[7:4]) == 4'hC) |->
        (next_pc[PC_W-1:PAGE_LO] == $past(pc_inc[PC_W-1:PAGE_LO]) &&
         next_pc[PAGE_LO-1:DATA_W] == $past(opcode[2:0]) &&
         next_pc[DATA_W-1:0] == $past(imm8)));

    // The call indicator only follows a call opcode.
    assert_push_only_call_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push_ret |-> ($past(rst_n) &&
                      ($past(opcode[7:3]) == 5'b11001 || $past(opcode) == 8'hD9)));

    // Every call opcode raises the call indicator.
    assert_call_pushes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(opcode[7:3]) == 5'b11001 || $past(opcode) == 8'hD9))
        |-> push_ret);

    assert_long_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode[7:1]) == 7'b1101100) |->
        next_pc == $past(addr16));

    assert_return_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode[7:1]) == 7'b1101101) |->
        next_pc == $past(stack_ret));

    assert_dptr_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode) == 8'hDE) |->
        next_pc == $past(dptr));

    assert_plain_sequential_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(opcode[7:6]) != 2'b11 || $past(opcode[7:3]) >= 5'b11101))
        |-> (next_pc == $past(pc_inc) && !push_ret));

endmodule

bind pcu_next_pc pcu_next_pc_chk #(.PC_W(PC_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode    (opcode),
    .pc_inc    (pc_inc),
    .imm8      (imm8),
    .addr16    (addr16),
    .dptr      (dptr),
    .stack_ret (stack_ret),
    .next_pc   (next_pc),
    .push_ret  (push_ret)
);

// File: tb/pcu_next_pc_tb_top.sv
// Bench for pcu_next_pc: a behavioural reference computes the expected
// next address for the inputs driven before each edge and compares it
// with the outputs on every clock.
module pcu_next_pc_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] pc_inc = 16'h0000;
    logic [7:0]  imm8 = 8'h00;
    logic [7:0]  cmp8 = 8'h00;
    logic [15:0] addr16 = 16'h0000;
    logic [7:0]  acc = 8'h00;
    logic [15:0] dptr = 16'h0000;
    logic [15:0] stack_ret = 16'h0000;
    logic [7:0]  reg_val = 8'h00;
    logic        flag_z = 1'b0;
    logic        flag_c = 1'b0;
    logic        flag_p = 1'b0;
    logic        flag_s = 1'b0;
    logic [15:0] next_pc;
    logic        push_ret;

    int    n_checks = 0;
    int    n_bad = 0;
    bit    pending = 1'b0;
    bit    finished = 1'b0;
    logic [15:0] exp_pc;
    logic        exp_push;
    string       exp_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcu_next_pc dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .opcode    (opcode),
        .pc_inc    (pc_inc),
        .imm8      (imm8),
        .cmp8      (cmp8),
        .addr16    (addr16),
        .acc       (acc),
        .dptr      (dptr),
        .stack_ret (stack_ret),
        .reg_val   (reg_val),
        .flag_z    (flag_z),
        .flag_c    (flag_c),
        .flag_p    (flag_p),
        .flag_s    (flag_s),
        .next_pc   (next_pc),
        .push_ret  (push_ret)
    );

    // Behavioural reference, written from the requirements.
    function automatic void ref_model(output logic [15:0] npc,
                                      output logic psh, output string tag);
        int unsigned rel;
        int unsigned op;
        op  = opcode;
        rel = (int'(pc_inc) + int'($signed(imm8))) & 32'hFFFF;
        npc = pc_inc;
        psh = 1'b0;
        tag = "R11";
        if (op >= 8'hC0 && op <= 8'hCF) begin
            npc = {pc_inc[15:11], opcode[2:0], imm8};
            psh = (op >= 8'hC8);
            tag = "R2/R3";
        end else if (op <= 8'hD3 && op >= 8'hD0) begin
            if (reg_val != 8'h01) npc = rel[15:0];
            tag = "R9";
        end else if (op <= 8'hD7 && op >= 8'hD4) begin
            if (reg_val != cmp8) npc = rel[15:0];
            tag = "R10";
        end else if (op == 8'hDF) begin
            if (acc != cmp8) npc = rel[15:0];
            tag = "R10";
        end else if (op == 8'hD8 || op == 8'hD9) begin
            npc = addr16;
            psh = (op == 8'hD9);
            tag = "R4/R3";
        end else if (op == 8'hDA || op == 8'hDB) begin
            npc = stack_ret;
            tag = "R5";
        end else if (op == 8'hDC) begin
            npc = rel[15:0];
            tag = "R6";
        end else if (op == 8'hDD) begin
            npc = 16'((int'(dptr) + int'(acc)) & 32'hFFFF);
            tag = "R7";
        end else if (op == 8'hDE) begin
            npc = dptr;
            tag = "R7";
        end else if (op >= 8'hE0 && op <= 8'hE7) begin
            bit cnd;
            case (op & 7)
                0: cnd = flag_z;
                1: cnd = !flag_z;
                2: cnd = flag_c;
                3: cnd = !flag_c;
                4: cnd = flag_p;
                5: cnd = !flag_p;
                6: cnd = flag_s;
                default: cnd = !flag_s;
            endcase
            if (cnd) npc = rel[15:0];
            tag = "R8";
        end
    endfunction

    // Compare the outputs seen after an edge with the predicted values.
    task automatic compare_pending();
        if (pending) begin
            n_checks++;
            if (next_pc !== exp_pc || push_ret !== exp_push) begin
                n_bad++;
                $display("FAIL %s/R12 op=%02h: next_pc=%04h push=%0b expected next_pc=%04h push=%0b",
                         exp_tag, opcode, next_pc, push_ret, exp_pc, exp_push);
            end
        end
    endtask

    // Finish the previous check, then drive one instruction's inputs.
    task automatic drive(input logic [7:0] op, input logic [15:0] pci,
                         input logic [7:0] im, input logic [7:0] cm,
                         input logic [15:0] a16, input logic [7:0] ac,
                         input logic [15:0] dp, input logic [15:0] sr,
                         input logic [7:0] rv, input logic [3:0] fl);
        @(negedge clk);
        compare_pending();
        opcode = op; pc_inc = pci; imm8 = im; cmp8 = cm; addr16 = a16;
        acc = ac; dptr = dp; stack_ret = sr; reg_val = rv;
        {flag_s, flag_p, flag_c, flag_z} = fl;
        ref_model(exp_pc, exp_push, exp_tag);
        pending = 1'b1;
    endtask

    task automatic check_reset(input string what);
        n_checks++;
        if (next_pc !== 16'h0000 || push_ret !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 %s: next_pc=%04h push=%0b expected next_pc=0000 push=0",
                     what, next_pc, push_ret);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state, with a call opcode presented during reset.
        opcode = 8'hD9; addr16 = 16'h1234;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset("initial");
        rst_n = 1'b1;

        // R2 / R3: page jump and page call near the top of memory.
        drive(8'hC5, 16'hF812, 8'h3C, 8'h00, 16'h0000, 8'h00, 16'h0000, 16'h0000, 8'h00, 4'h0);
        drive(8'hCF, 16'h0803, 8'hA5, 8'h00, 16'h0000, 8'h00, 16'h0000, 16'h0000, 8'h00, 4'h0);
        // R4 / R3: long jump and long call.
        drive(8'hD8, 16'h0100, 8'h00, 8'h00, 16'hBEEF, 8'h00, 16'h0000, 16'h0000, 8'h00, 4'h0);
        drive(8'hD9, 16'h0100, 8'h00, 8'h00, 16'hCAFE, 8'h00, 16'h0000, 16'h0000, 8'h00, 4'h0);
        // R5: both return opcodes.
        drive(8'hDA, 16'h0200, 8'h00, 8'h00, 16'h0000, 8'h00, 16'h0000, 16'h4321, 8'h00, 4'h0);
        drive(8'hDB, 16'h0200, 8'h00, 8'h00, 16'h0000, 8'h00, 16'h0000, 16'h8765, 8'h00, 4'h0);
        // R6: most negative displacement and wrap past the top.
        drive(8'hDC, 16'h0010, 8'h80, 8'h00, 16'h0000, 8'h00, 16'h0000, 16'h0000, 8'h00, 4'h0);
        drive(8'hDC, 16'hFFF0, 8'h7F, 8'h00, 16'h0000, 8'h00, 16'h0000, 16'h0000, 8'h00, 4'h0);
        // R7: indexed jump wrapping, accumulator unsigned; direct pointer jump.
        drive(8'hDD, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'hFF, 16'hFFFF, 16'h0000, 8'h00, 4'h0);
        drive(8'hDE, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'hFF, 16'h5A5A, 16'h0000, 8'h00, 4'h0);
        // R8: each flag test, taken then not taken.
        for (int i = 0; i < 8; i++) begin
            logic [3:0] fl;
            fl = 4'b0001 << (i / 2);
            drive(8'hE0 + 8'(i), 16'h3000, 8'hF0, 8'h00, 16'h0000, 8'h00, 16'h0000, 16'h0000, 8'h00, fl);
            drive(8'hE0 + 8'(i), 16'h3000, 8'hF0, 8'h00, 16'h0000, 8'h00, 16'h0000, 16'h0000, 8'h00, ~fl);
        end
        // R9: counter at one falls through, at zero wraps and branches.
        drive(8'hD2, 16'h4000, 8'h10, 8'h00, 16'h0000, 8'h00, 16'h0000, 16'h0000, 8'h01, 4'h0);
        drive(8'hD2, 16'h4000, 8'h10, 8'h00, 16'h0000, 8'h00, 16'h0000, 16'h0000, 8'h00, 4'h0);
        // R10: equal compare falls through, unequal branches; accumulator form.
        drive(8'hD5, 16'h5000, 8'hFE, 8'h33, 16'h0000, 8'h00, 16'h0000, 16'h0000, 8'h33, 4'h0);
        drive(8'hD5, 16'h5000, 8'hFE, 8'h34, 16'h0000, 8'h00, 16'h0000, 16'h0000, 8'h33, 4'h0);
        drive(8'hDF, 16'h5000, 8'h02, 8'h77, 16'h0000, 8'h77, 16'h0000, 16'h0000, 8'h00, 4'h0);
        drive(8'hDF, 16'h5000, 8'h02, 8'h77, 16'h0000, 8'h76, 16'h0000, 16'h0000, 8'h77, 4'h0);
        // R11: non-control opcodes ignore every operand.
        drive(8'h1F, 16'h6000, 8'h99, 8'h00, 16'hFFFF, 8'h12, 16'hAAAA, 16'h5555, 8'h00, 4'hF);
        drive(8'hFB, 16'h6001, 8'h99, 8'h00, 16'hFFFF, 8'h12, 16'hAAAA, 16'h5555, 8'h00, 4'hF);

        // Random stream, compared every clock.
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] op;
            logic [7:0] rv;
            logic [7:0] cm;
            op = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(8'hC0, 8'hFF));
            rv = 8'($urandom);
            if ($urandom_range(0, 3) == 0) rv = 8'($urandom_range(0, 1));
            cm = ($urandom_range(0, 2) == 0) ? rv : 8'($urandom);
            if (op == 8'hDF && $urandom_range(0, 1) == 1) cm = 8'h5C;
            drive(op, 16'($urandom), 8'($urandom), cm, 16'($urandom),
                  (op == 8'hDF && cm == 8'h5C) ? 8'h5C : 8'($urandom),
                  16'($urandom), 16'($urandom), rv, 4'($urandom));
        end

        // R1: reset in the middle of traffic clears the outputs.
        @(negedge clk);
        compare_pending();
        pending = 1'b0;
        rst_n = 1'b0;
        opcode = 8'hC9;
        @(negedge clk);
        check_reset("mid-run");
        rst_n = 1'b1;
        drive(8'hC9, 16'h7777, 8'h01, 8'h00, 16'h0000, 8'h00, 16'h0000, 16'h0000, 8'h00, 4'h0);
        @(negedge clk);
        compare_pending();
        finish_run();
    end

endmodule